// File: doc/BRIEF.md
# Byte-Lane Memory with Single-Error Correction

This block is a synthesizable word memory. Each 32-bit word is split into four byte lanes and stored together with six Hamming check bits. The memory answers only while all three of its active-low chip selects are low. A write stores only the lanes whose active-low byte enable is low. To do this it first corrects the old word, then merges in the new bytes, and then encodes the whole word again. A read returns corrected data one clock after the request. It drives only the enabled lanes and reports whether a stored bit had to be fixed.

Pad tri-states are modelled as data plus an output-enable for each lane, and one output-enable for the error flag. A corrected word is never written back by a read, so a stored fault stays until a write covers that word. A test port flips any single bit of any stored codeword, so the correction path and the error flag can be exercised.

Top module: `ecc_bytelane_mem`

## Requirements
- R1: The memory is selected only when all three bits of `sel_n` are 0. With any bit at 1, a write request leaves the array unchanged and no output is enabled.
- R2: A selected cycle with `wr_n`=0 updates only the lanes whose `lane_en_n` bit is 0. Lane i is bits 8i+7:8i. `rd_en_n` has no effect on a write. A write with all four enables at 1 changes nothing.
- R3: A selected cycle with `wr_n`=1 and `rd_en_n`=0 is a read. In the next cycle, `lane_oe` bit i is 1 exactly when `lane_en_n` bit i was 0, and `rdata` carries the corrected word on those lanes.
- R4: `lane_oe` is 0000 after a cycle that was deselected, had `rd_en_n`=1, had all lane enables at 1, or was a write. Any byte of `rdata` whose lane is not enabled reads as 0.
- R5: When the addressed codeword holds exactly one flipped bit, whether a data bit or a check bit, the read returns the original data with `err_flag`=1 and `err_oe`=1.
- R6: A read of an error-free word gives `err_oe`=1 and `err_flag`=0.
- R7: `err_oe` and `err_flag` are 0 after a cycle that was deselected, had `rd_en_n`=1, had all lane enables at 1, or was a write.
- R8: A read never repairs the array. Reading a faulty word again flags the error again.
- R9: A partial write to a faulty word stores the corrected old bytes merged with the new ones. A later read returns the merged word with `err_flag`=0.
- R10: When `inj_en`=1, bit `inj_bit` of the codeword at `inj_addr` is inverted at the clock edge. An index of 38 or above is ignored. The injection is dropped if a write hits the same word in the same cycle.
- R11: Reset clears every stored word to zero and all outputs to 0. A read after reset returns 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all requests are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 3 | Three active-low chip selects |
| wr_n | input | 1 | Active-low write request |
| rd_en_n | input | 1 | Active-low output enable |
| lane_en_n | input | 4 | Active-low byte-lane enables |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| inj_en | input | 1 | Fault-injection strobe |
| inj_addr | input | ADDR_W | Word to corrupt |
| inj_bit | input | 6 | Codeword bit index to invert (0..37) |
| rdata | output | 32 | Corrected read data, zero on disabled lanes |
| lane_oe | output | 4 | Per-lane drive enable for `rdata` |
| err_flag | output | 1 | A single-bit correction happened on this read |
| err_oe | output | 1 | Drive enable for `err_flag` |

## Verification
The bench targets a partial write over a word that already holds a fault. A design that merged with the raw stored bytes would re-encode the fault into the data, and the read would return a wrong byte with no flag. It also flips a check bit rather than a data bit. A decoder that ignored check-bit positions would miss that flag.

Two more cases cover the edges of the read and write paths. Repeated reads of a faulty word expose an implementation that scrubs silently, because the second read would come back clean. A write with every lane disabled, and writes with one chip select high, catch designs that still rewrite the word or drive outputs. Out-of-range and write-colliding injections check that the test port cannot corrupt a word it should leave alone.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int CHK_W  = 6;
    localparam int CW_W   = DATA_W + CHK_W;
    localparam int IDX_W  = 6;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [LANES-1:0]  lane_oe;
        logic              err_oe;
        logic              err_flag;
    } rd_out_t;

    // Hamming position (1-based) that holds data bit j: the j-th non power of two
    function automatic int data_pos(input int j);
        int seen;
        seen = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == j) return p;
                seen++;
            end
        end
        return 0;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_mem_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CW_W-1:0]   code
);
    always_comb begin
        logic par;
        code = '0;
        for (int j = 0; j < DATA_W; j++) begin
            code[data_pos(j) - 1] = data[j];
        end
        for (int k = 0; k < CHK_W; k++) begin
            par = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> k) & 1) == 1) par = par ^ code[p - 1];
            end
            code[(1 << k) - 1] = par;
        end
    end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
    import ecc_mem_pkg::*;
(
    input  logic [CW_W-1:0]   code,
    output logic [DATA_W-1:0] data,
    output logic              corrected
);
    logic [CHK_W-1:0] syn;
    logic [CW_W-1:0]  fixed;

    always_comb begin
        syn = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (code[p - 1]) syn = syn ^ CHK_W'(p);
        end
        fixed = code;
        if (syn != '0 && int'(syn) <= CW_W) begin
            fixed[int'(syn) - 1] = ~code[int'(syn) - 1];
        end
        for (int j = 0; j < DATA_W; j++) begin
            data[j] = fixed[data_pos(j) - 1];
        end
        corrected = (syn != '0);
    end
endmodule

// File: rtl/codeword_store.sv
module codeword_store
    import ecc_mem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW_W-1:0]   rd_code,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW_W-1:0]   wr_code,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [IDX_W-1:0]  inj_bit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CW_W-1:0] mem_q [DEPTH];
    logic [CW_W-1:0] inj_mask;
    logic            inj_take;

    assign rd_code  = mem_q[rd_addr];
    assign inj_mask = (int'(inj_bit) < CW_W) ? (CW_W'(1) << inj_bit) : '0;
    assign inj_take = inj_en && !(wr_en && (inj_addr == wr_addr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (wr_en)    mem_q[wr_addr]  <= wr_code;
            if (inj_take) mem_q[inj_addr] <= mem_q[inj_addr] ^ inj_mask;
        end
    end
endmodule

// File: rtl/ecc_bytelane_mem.sv
module ecc_bytelane_mem
    import ecc_mem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel_n,
    input  logic              wr_n,
    input  logic              rd_en_n,
    input  logic [3:0]        lane_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [5:0]        inj_bit,
    output logic [31:0]       rdata,
    output logic [3:0]        lane_oe,
    output logic              err_flag,
    output logic              err_oe
);
    logic            selected, wr_req, rd_req, any_lane;
    logic [CW_W-1:0] old_code, new_code;
    logic [DATA_W-1:0] old_data, merged;
    logic            old_err;
    rd_out_t         out_d, out_q;

    assign selected = (sel_n == 3'b000);
    assign any_lane = (lane_en_n != '1);
    assign wr_req   = selected && !wr_n;
    assign rd_req   = selected && wr_n && !rd_en_n && any_lane;

    codeword_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(addr), .rd_code(old_code),
        .wr_en(wr_req && any_lane), .wr_addr(addr), .wr_code(new_code),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit)
    );

    ecc_decoder u_dec (.code(old_code), .data(old_data), .corrected(old_err));

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[8*g +: 8] = lane_en_n[g] ? old_data[8*g +: 8] : wdata[8*g +: 8];
    end

    ecc_encoder u_enc (.data(merged), .code(new_code));

    always_comb begin
        out_d = '0;
        if (rd_req) begin
            out_d.lane_oe  = ~lane_en_n;
            for (int i = 0; i < LANES; i++) begin
                out_d.rdata[8*i +: 8] = lane_en_n[i] ? 8'h00 : old_data[8*i +: 8];
            end
            out_d.err_oe   = 1'b1;
            out_d.err_flag = old_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rdata    = out_q.rdata;
    assign lane_oe  = out_q.lane_oe;
    assign err_flag = out_q.err_flag;
    assign err_oe   = out_q.err_oe;
endmodule

// File: rtl/ecc_bytelane_mem_chk.sv
module ecc_bytelane_mem_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  sel_n,
    input logic        wr_n,
    input logic        rd_en_n,
    input logic [3:0]  lane_en_n,
    input logic [31:0] rdata,
    input logic [3:0]  lane_oe,
    input logic        err_flag,
    input logic        err_oe
);
    p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n != 3'b000) |=> (lane_oe == 4'b0000 && !err_oe));

    p_write_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n == 3'b000 && !wr_n) |=> (lane_oe == 4'b0000));

    p_lane_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n == 3'b000 && wr_n && !rd_en_n) |=> (lane_oe == ~$past(lane_en_n)));

    p_err_driven_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n == 3'b000 && wr_n && !rd_en_n && lane_en_n != 4'hF) |=> err_oe);

    p_err_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_n || lane_en_n == 4'hF) |=> (!err_oe && !err_flag));

    p_flag_needs_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> err_oe);

    p_idle_bytes_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata & ~{{8{lane_oe[3]}}, {8{lane_oe[2]}}, {8{lane_oe[1]}}, {8{lane_oe[0]}}}) == 32'h0));
endmodule

bind ecc_bytelane_mem ecc_bytelane_mem_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_en_n(rd_en_n),
    .lane_en_n(lane_en_n), .rdata(rdata), .lane_oe(lane_oe),
    .err_flag(err_flag), .err_oe(err_oe)
);

// File: tb/ecc_bytelane_mem_tb.sv
module ecc_bytelane_mem_tb;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    sel_n = 3'b111;
    logic          wr_n = 1'b1, rd_en_n = 1'b1;
    logic [3:0]    lane_en_n = 4'hF;
    logic [AW-1:0] addr = '0, inj_addr = '0;
    logic [31:0]   wdata = '0;
    logic          inj_en = 1'b0;
    logic [5:0]    inj_bit = '0;
    logic [31:0]   rdata;
    logic [3:0]    lane_oe;
    logic          err_flag, err_oe;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] data;
        logic [3:0]  loe;
        logic        eoe;
        logic        eflag;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    ecc_bytelane_mem #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_en_n(rd_en_n),
        .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata), .inj_en(inj_en),
        .inj_addr(inj_addr), .inj_bit(inj_bit), .rdata(rdata), .lane_oe(lane_oe),
        .err_flag(err_flag), .err_oe(err_oe)
    );

    function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = be_n[i] ? 8'h00 : 8'hFF;
        return m;
    endfunction

    // monitor: compares what the DUT registered on the last edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rdata !== e.data || lane_oe !== e.loe || err_oe !== e.eoe || err_flag !== e.eflag) begin
                fails++;
                $display("FAIL %s: got data=%h loe=%b eoe=%b err=%b, expected data=%h loe=%b eoe=%b err=%b",
                         e.tag, rdata, lane_oe, err_oe, err_flag, e.data, e.loe, e.eoe, e.eflag);
            end
        end
    end

    task automatic drive(input logic [2:0] s, input logic w, input logic o, input logic [3:0] b,
                         input logic [AW-1:0] a, input logic [31:0] d, input exp_t e);
        @(negedge clk);
        sel_n = s; wr_n = w; rd_en_n = o; lane_en_n = b; addr = a; wdata = d;
        inj_en = 1'b0;
        sb.push_back(e);
    endtask

    function automatic exp_t quiet(input string t);
        exp_t e;
        e.data = '0; e.loe = '0; e.eoe = 1'b0; e.eflag = 1'b0; e.tag = t;
        return e;
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [3:0] b, input logic [31:0] d,
                      input logic o, input string t);
        drive(3'b000, 1'b0, o, b, a, d, quiet(t));
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [3:0] b, input logic [31:0] word,
                      input logic flag, input string t);
        exp_t e;
        e.data = word & lane_mask(b); e.loe = ~b; e.eoe = 1'b1; e.eflag = flag; e.tag = t;
        drive(3'b000, 1'b1, 1'b0, b, a, 32'h0, e);
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [5:0] bitx, input string t);
        drive(3'b111, 1'b1, 1'b1, 4'hF, '0, 32'h0, quiet(t));
        inj_en = 1'b1; inj_addr = a; inj_bit = bitx;
    endtask

    initial begin
        #(5 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rdata !== 32'h0 || lane_oe !== 4'h0 || err_oe !== 1'b0 || err_flag !== 1'b0) begin
            fails++;
            $display("FAIL R11: got data=%h loe=%b eoe=%b err=%b, expected all zero",
                     rdata, lane_oe, err_oe, err_flag);
        end
        rst_n = 1'b1;

        rd(8'd5, 4'h0, 32'h0, 1'b0, "R11 cleared word");
        wr(8'd5, 4'h0, 32'hA1B2C3D4, 1'b0, "R4 R7 write with oe low stays quiet");
        rd(8'd5, 4'h0, 32'hA1B2C3D4, 1'b0, "R3 R6 full read");
        wr(8'd5, 4'b1101, 32'hFFEEDDCC, 1'b1, "R2 lane B write");
        rd(8'd5, 4'h0, 32'hA1B2DDD4, 1'b0, "R2 only lane B changed");
        rd(8'd5, 4'b1010, 32'hA1B2DDD4, 1'b0, "R3 R4 lanes A and C");
        drive(3'b000, 1'b1, 1'b1, 4'h0, 8'd5, 32'h0, quiet("R4 R7 output enable high"));
        drive(3'b000, 1'b1, 1'b0, 4'hF, 8'd5, 32'h0, quiet("R4 R7 all lanes off"));
        drive(3'b011, 1'b0, 1'b0, 4'h0, 8'd5, 32'h0, quiet("R1 deselected write"));
        drive(3'b101, 1'b1, 1'b0, 4'h0, 8'd5, 32'h0, quiet("R1 deselected read"));
        drive(3'b110, 1'b0, 1'b0, 4'h0, 8'd5, 32'h0, quiet("R1 deselected write 2"));
        wr(8'd5, 4'hF, 32'h0, 1'b1, "R2 no-lane write");
        rd(8'd5, 4'h0, 32'hA1B2DDD4, 1'b0, "R1 R2 word untouched");

        inject(8'd5, 6'd17, "R10 inject data bit");
        rd(8'd5, 4'h0, 32'hA1B2DDD4, 1'b1, "R5 R10 corrected read");
        rd(8'd5, 4'h0, 32'hA1B2DDD4, 1'b1, "R8 fault persists");

        wr(8'd9, 4'h0, 32'h12345678, 1'b1, "R2 write addr 9");
        inject(8'd9, 6'd0, "R10 inject check bit");
        rd(8'd9, 4'h0, 32'h12345678, 1'b1, "R5 check-bit fault");

        wr(8'd5, 4'b0111, 32'h7F000000, 1'b1, "R9 merge write over fault");
        rd(8'd5, 4'h0, 32'h7FB2DDD4, 1'b0, "R9 merged and clean");

        wr(8'd12, 4'h0, 32'hCAFE0001, 1'b1, "R2 write addr 12");
        inject(8'd12, 6'd40, "R10 out-of-range index");
        rd(8'd12, 4'h0, 32'hCAFE0001, 1'b0, "R10 index 40 ignored");

        drive(3'b000, 1'b0, 1'b1, 4'h0, 8'd20, 32'h0BADF00D, quiet("R10 write with colliding inject"));
        inj_en = 1'b1; inj_addr = 8'd20; inj_bit = 6'd3;
        rd(8'd20, 4'h0, 32'h0BADF00D, 1'b0, "R10 colliding inject dropped");
        rd(8'd20, 4'b1110, 32'h0BADF00D, 1'b0, "R3 lane A only");

        drive(3'b111, 1'b1, 1'b1, 4'hF, '0, 32'h0, quiet("R1 idle"));
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule